// File: doc/BRIEF.md
# Threshold Write-Protect Permission Gate

This block sits behind the command decoder of a 256-word by 16-bit serial non-volatile memory. For each command it decides whether that command may go ahead. The decoder presents one command per `cmd_valid` pulse, together with the target word address and the levels of the program-enable and protect-enable pins as they were while the command was shifted in. One cycle later the gate answers with `done` and a `permit` bit. The serial front end and the cell programming engine act on that answer.

The gate holds four pieces of state:
- an erase/write enable latch;
- a protect threshold address with its own "cleared" flag;
- an arming flag that survives for exactly one following command;
- a one-time lock.

When the threshold is valid, every word at or above it refuses erase and write. Changing the threshold takes an arming command immediately before the change. Once the lock is set, the threshold can never change again.

The enable latch and the arming flag are ordinary volatile state, and `rst_n` clears them. The threshold, its cleared flag and the lock model non-volatile cells. `rst_n` leaves them alone, and only the initialisation input `nv_init` resets them. `nv_init` is intended for test use only.

Top module: `prot_gate`

## Requirements
- R1: When `prot_clear` is 0, an erase (code 3) or write (code 4) whose address is greater than or equal to `prot_addr` is refused. When `prot_clear` is 1, no address is protected.
- R2: After `rst_n` the enable latch is off. The following commands are refused while the latch is off: erase (3), write (4), erase-all (5), write-all (6) and arm (8). An accepted enable (1) turns the latch on, and an accepted disable (2) turns it off.
- R3: The following commands are refused unless `pe_lvl` is 1: enable (1), erase (3), write (4), erase-all (5), write-all (6), arm (8), protect-clear (9), protect-write (10) and lock (11).
- R4: Codes 7 to 11 are refused unless `pre_lvl` is 1. Codes 0 to 6 are refused unless `pre_lvl` is 0. Code 0 is read, and code 7 is protect-read.
- R5: Protect-clear (9), protect-write (10) and lock (11) are accepted only if the command just before them was an accepted arm (8). Any command in between cancels the arming, whether that command is accepted or refused. Idle cycles do not cancel it.
- R6: Protect-write is refused unless `prot_clear` is 1. When accepted, it loads `cmd_addr` into `prot_addr` and drives `prot_clear` to 0.
- R7: After an accepted lock, every later protect-clear and protect-write is refused. After the lock, `prot_addr` and `prot_clear` never change.
- R8: Erase-all (5) and write-all (6) are accepted only while `prot_clear` is 1.
- R9: A `cmd_valid` pulse in one cycle gives `done` = 1 in the next cycle, with `permit` carrying the decision. `permit` is 0 whenever `done` is 0. Codes 12 to 15 are always refused.
- R10: `rst_n` leaves `prot_addr`, `prot_clear` and the lock unchanged. `nv_init` sets `prot_clear` to 1, sets `prot_addr` to 0 and unlocks the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset of the volatile state |
| nv_init | input | 1 | Initialisation of the non-volatile state, for test use only |
| cmd_valid | input | 1 | One-cycle pulse that presents a decoded command |
| cmd_op | input | 4 | Command code |
| cmd_addr | input | ADDR_W | Target word address, or the new threshold |
| pe_lvl | input | 1 | Program-enable pin level seen while the command was loaded |
| pre_lvl | input | 1 | Protect-enable pin level seen while the command was loaded |
| done | output | 1 | Decision valid |
| permit | output | 1 | 1 = the command may run, 0 = abort |
| prot_addr | output | ADDR_W | Stored threshold, for readback |
| prot_clear | output | 1 | 1 = the threshold register is cleared |

## Verification
The bench builds the gate with `ADDR_W` = 4. With that setting the bench can reach both the lowest and the highest word, 0 and 15, directly. A threshold of 0 then blocks the whole array, and a cleared register lets address 15 through. The same 4-bit space places the boundary pair 7/8 on either side of a threshold of 8, and a vector of a few dozen commands takes the register from arming through clearing and locking. The bench also runs the reset and `nv_init` sequences to show which state survives each of them.

// File: rtl/prot_gate.sv
module prot_gate #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nv_init,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              pe_lvl,
  input  logic              pre_lvl,
  output logic              done,
  output logic              permit,
  output logic [ADDR_W-1:0] prot_addr,
  output logic              prot_clear
);
  localparam logic [3:0] OP_RD = 4'd0, OP_EN = 4'd1, OP_DIS = 4'd2, OP_ERA = 4'd3,
                         OP_WR = 4'd4, OP_ERAL = 4'd5, OP_WRAL = 4'd6, OP_PRRD = 4'd7,
                         OP_ARM = 4'd8, OP_PCLR = 4'd9, OP_PWR = 4'd10, OP_LOCK = 4'd11;

  logic wen_q, armed_q, lock_q, done_q, ok_q;
  logic [ADDR_W-1:0] pa_q;
  logic pclr_q;

  logic known, is_pr, pe_need, pins_ok, below, rule_ok, ok;

  assign known   = cmd_op <= OP_LOCK;
  assign is_pr   = cmd_op >= OP_PRRD;
  assign pe_need = !(cmd_op == OP_RD || cmd_op == OP_DIS || cmd_op == OP_PRRD);
  assign pins_ok = known && (pre_lvl == is_pr) && (pe_lvl || !pe_need);
  assign below   = pclr_q || (cmd_addr < pa_q);

  always_comb begin
    case (cmd_op)
      OP_RD, OP_EN, OP_DIS, OP_PRRD: rule_ok = 1'b1;
      OP_ERA, OP_WR:                 rule_ok = wen_q && below;
      OP_ERAL, OP_WRAL:              rule_ok = wen_q && pclr_q;
      OP_ARM:                        rule_ok = wen_q;
      OP_PCLR, OP_LOCK:              rule_ok = armed_q && !lock_q;
      OP_PWR:                        rule_ok = armed_q && !lock_q && pclr_q;
      default:                       rule_ok = 1'b0;
    endcase
  end

  assign ok = pins_ok && rule_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wen_q   <= 1'b0;
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      ok_q    <= 1'b0;
    end else begin
      done_q <= cmd_valid;
      ok_q   <= cmd_valid && ok;
      if (cmd_valid) begin
        armed_q <= (cmd_op == OP_ARM) && ok;
        if (ok && cmd_op == OP_EN)  wen_q <= 1'b1;
        if (ok && cmd_op == OP_DIS) wen_q <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (nv_init) begin
      lock_q <= 1'b0;
      pclr_q <= 1'b1;
      pa_q   <= '0;
    end else if (rst_n && cmd_valid && ok) begin
      case (cmd_op)
        OP_PCLR: begin pclr_q <= 1'b1; pa_q <= '0; end
        OP_PWR:  begin pclr_q <= 1'b0; pa_q <= cmd_addr; end
        OP_LOCK: lock_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign done       = done_q;
  assign permit     = ok_q;
  assign prot_addr  = pa_q;
  assign prot_clear = pclr_q;
endmodule

// File: rtl/prot_gate_chk.sv
module prot_gate_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              nv_init,
  input logic              cmd_valid,
  input logic [3:0]        cmd_op,
  input logic [ADDR_W-1:0] cmd_addr,
  input logic              pe_lvl,
  input logic              done,
  input logic              permit,
  input logic [ADDR_W-1:0] prot_addr,
  input logic              prot_clear,
  input logic              wen_q,
  input logic              lock_q
);
  AST_PROTECTED_WRITE_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && permit && ($past(cmd_op) == 4'd3 || $past(cmd_op) == 4'd4))
    |-> ($past(prot_clear) || $past(cmd_addr) < $past(prot_addr))); // R1
  AST_PROG_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && permit && $past(cmd_op) >= 4'd3 && $past(cmd_op) <= 4'd6) |-> $past(wen_q)); // R2
  AST_PE_NEEDED: assert property (@(posedge clk) disable iff (!rst_n)
    (done && permit && $past(cmd_op) >= 4'd8) |-> $past(pe_lvl)); // R3
  AST_LOCK_FREEZES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(lock_q) && !$past(nv_init)) |-> ($stable(prot_addr) && $stable(prot_clear))); // R7
  AST_BULK_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && permit && ($past(cmd_op) == 4'd5 || $past(cmd_op) == 4'd6)) |-> $past(prot_clear)); // R8
  AST_DECISION_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> done); // R9
  AST_PERMIT_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    permit |-> done); // R9
endmodule

bind prot_gate prot_gate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .nv_init(nv_init), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
  .cmd_addr(cmd_addr), .pe_lvl(pe_lvl), .done(done), .permit(permit),
  .prot_addr(prot_addr), .prot_clear(prot_clear), .wen_q(wen_q), .lock_q(lock_q)
);

// File: tb/prot_gate_bench.sv
module prot_gate_bench;
  localparam int AW = 4;
  localparam int NV = 36;
  // fields: [14:11] req, [10:7] op, [6:3] addr, [2] pe, [1] pre, [0] expected permit
  localparam logic [14:0] VEC [NV] = '{
    {4'd2, 4'd4,  4'd3,  1'b1, 1'b0, 1'b0},  // R2 write while disabled
    {4'd3, 4'd1,  4'd0,  1'b0, 1'b0, 1'b0},  // R3 enable without PE
    {4'd4, 4'd1,  4'd0,  1'b1, 1'b1, 1'b0},  // R4 enable with PRE high
    {4'd2, 4'd1,  4'd0,  1'b1, 1'b0, 1'b1},  // R2 enable
    {4'd1, 4'd4,  4'd15, 1'b1, 1'b0, 1'b1},  // R1 cleared protects nothing
    {4'd8, 4'd5,  4'd0,  1'b1, 1'b0, 1'b1},  // R8 erase-all when cleared
    {4'd5, 4'd9,  4'd0,  1'b1, 1'b1, 1'b0},  // R5 clear without arming
    {4'd4, 4'd8,  4'd0,  1'b1, 1'b0, 1'b0},  // R4 arm with PRE low
    {4'd5, 4'd8,  4'd0,  1'b1, 1'b1, 1'b1},  // R5 arm
    {4'd5, 4'd0,  4'd0,  1'b0, 1'b0, 1'b1},  // R5 read in between
    {4'd5, 4'd10, 4'd8,  1'b1, 1'b1, 1'b0},  // R5 arming cancelled
    {4'd5, 4'd8,  4'd0,  1'b1, 1'b1, 1'b1},  // R5 arm
    {4'd6, 4'd10, 4'd8,  1'b1, 1'b1, 1'b1},  // R6 threshold 8
    {4'd4, 4'd7,  4'd0,  1'b0, 1'b1, 1'b1},  // R4 protect-read
    {4'd1, 4'd4,  4'd8,  1'b1, 1'b0, 1'b0},  // R1 at threshold
    {4'd1, 4'd4,  4'd7,  1'b1, 1'b0, 1'b1},  // R1 just below
    {4'd1, 4'd3,  4'd9,  1'b1, 1'b0, 1'b0},  // R1 erase above
    {4'd8, 4'd6,  4'd0,  1'b1, 1'b0, 1'b0},  // R8 write-all while set
    {4'd5, 4'd8,  4'd0,  1'b1, 1'b1, 1'b1},
    {4'd6, 4'd10, 4'd4,  1'b1, 1'b1, 1'b0},  // R6 not cleared
    {4'd5, 4'd8,  4'd0,  1'b1, 1'b1, 1'b1},
    {4'd5, 4'd9,  4'd0,  1'b1, 1'b1, 1'b1},  // R5 clear
    {4'd8, 4'd6,  4'd0,  1'b1, 1'b0, 1'b1},  // R8 write-all after clear
    {4'd5, 4'd8,  4'd0,  1'b1, 1'b1, 1'b1},
    {4'd6, 4'd10, 4'd12, 1'b1, 1'b1, 1'b1},  // R6 threshold 12
    {4'd5, 4'd8,  4'd0,  1'b1, 1'b1, 1'b1},
    {4'd7, 4'd11, 4'd0,  1'b1, 1'b1, 1'b1},  // R7 lock
    {4'd5, 4'd8,  4'd0,  1'b1, 1'b1, 1'b1},
    {4'd7, 4'd9,  4'd0,  1'b1, 1'b1, 1'b0},  // R7 clear after lock
    {4'd5, 4'd8,  4'd0,  1'b1, 1'b1, 1'b1},
    {4'd7, 4'd10, 4'd2,  1'b1, 1'b1, 1'b0},  // R7 write after lock
    {4'd3, 4'd3,  4'd0,  1'b0, 1'b0, 1'b0},  // R3 erase without PE
    {4'd9, 4'd12, 4'd0,  1'b1, 1'b0, 1'b0},  // R9 unlisted code
    {4'd2, 4'd2,  4'd0,  1'b0, 1'b0, 1'b1},  // R2 disable
    {4'd2, 4'd4,  4'd0,  1'b1, 1'b0, 1'b0},  // R2 write after disable
    {4'd2, 4'd8,  4'd0,  1'b1, 1'b1, 1'b0}   // R2 arm while disabled
  };

  logic clk = 1'b0, rst_n = 1'b0, nv_init = 1'b1, cmd_valid = 1'b0;
  logic [3:0] cmd_op = '0;
  logic [AW-1:0] cmd_addr = '0;
  logic pe_lvl = 1'b0, pre_lvl = 1'b0;
  logic done, permit, prot_clear;
  logic [AW-1:0] prot_addr;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  prot_gate #(.ADDR_W(AW)) u_prot_gate (
    .clk(clk), .rst_n(rst_n), .nv_init(nv_init), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_addr(cmd_addr), .pe_lvl(pe_lvl), .pre_lvl(pre_lvl), .done(done), .permit(permit),
    .prot_addr(prot_addr), .prot_clear(prot_clear)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic issue(input string req, input logic [3:0] op, input logic [AW-1:0] a,
                       input logic pe, input logic pre, input logic exp);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; pe_lvl = pe; pre_lvl = pre;
    @(negedge clk);
    cmd_valid = 1'b0;
    check({req, " done"}, {7'd0, done}, 8'd1);
    check({req, " permit"}, {7'd0, permit}, {7'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    nv_init = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 cleared after init", {7'd0, prot_clear}, 8'd1);
    check("R9 idle done", {7'd0, done}, 8'd0);
    for (int i = 0; i < NV; i++) begin
      issue($sformatf("R%0d vec%0d", VEC[i][14:11], i), VEC[i][10:7], VEC[i][6:3],
            VEC[i][2], VEC[i][1], VEC[i][0]);
      if (i == 12) check("R6 threshold loaded", {4'd0, prot_addr}, 8'd8);
    end
    check("R7 locked value", {4'd0, prot_addr}, 8'd12);
    check("R7 locked flag", {7'd0, prot_clear}, 8'd0);
    @(negedge clk);
    check("R9 no command no done", {6'd0, done, permit}, 8'd0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R10 reset keeps threshold", {4'd0, prot_addr}, 8'd12);
    issue("R2 write needs enable after reset", 4'd4, 4'd0, 1'b1, 1'b0, 1'b0);
    issue("R2 enable", 4'd1, 4'd0, 1'b1, 1'b0, 1'b1);
    issue("R5 arm", 4'd8, 4'd0, 1'b1, 1'b1, 1'b1);
    repeat (3) @(negedge clk);
    issue("R10 lock survives reset", 4'd9, 4'd0, 1'b1, 1'b1, 1'b0);
    nv_init = 1'b1;
    @(negedge clk);
    nv_init = 1'b0;
    check("R10 init clears", {7'd0, prot_clear}, 8'd1);
    issue("R5 arm", 4'd8, 4'd0, 1'b1, 1'b1, 1'b1);
    repeat (2) @(negedge clk);
    issue("R5 idle keeps arming", 4'd10, 4'd0, 1'b1, 1'b1, 1'b1);
    issue("R1 threshold zero blocks low", 4'd4, 4'd0, 1'b1, 1'b0, 1'b0);
    issue("R1 threshold zero blocks top", 4'd3, 4'd15, 1'b1, 1'b0, 1'b0);
    issue("R8 erase-all blocked", 4'd5, 4'd0, 1'b1, 1'b0, 1'b0);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule